// File: doc/BRIEF.md
# Operand Address Decoder for 16-bit Two-Byte Instruction Headers

This block takes the leading opcode byte and the addressing-mode byte of a 16-bit mode instruction, plus the displacement bytes that may follow them and the current values of the two base registers and two index registers. From these it produces the operand controls: the transfer direction, the operand width, the register-field index, the register-or-memory field index, a flag that says whether the second operand is in memory, the number of displacement bytes the instruction carries, the default segment choice (stack or data), and the 16-bit effective offset.

The decode is one registered stage. A cycle with `in_valid` high is captured at the rising clock edge, and all results appear together with `out_valid` one cycle later. Cycles with `in_valid` low leave every decoded output as it was. The address path sign-extends short displacements. It also treats the no-displacement pointer form as an absolute 16-bit address, and all offset sums wrap at 16 bits.

Top module: `operand_addr_decoder`

## Requirements
- R1: One cycle after a valid input, `opc` equals opcode byte bits 7:2, `dir_to_reg` equals bit 1 (1 = result goes to the register-field operand) and `wide` equals bit 0 (1 = 16-bit operand).
- R2: One cycle after a valid input, `reg_sel` equals mode byte bits 5:3 and `rm_sel` equals mode byte bits 2:0.
- R3: When mode byte bits 7:6 are 11 (register form), `is_mem` is 0, `disp_len` is 0, `seg_stack` is 0 and `eff_addr` is 0000h. For the three other values of bits 7:6, `is_mem` is 1.
- R4: When bits 7:6 are 01, `disp_len` is 1 and the low displacement byte is sign-extended before the add: 00h–7Fh becomes 0000h–007Fh and 80h–FFh becomes FF80h–FFFFh. The high displacement byte is ignored.
- R5: When bits 7:6 are 10, `disp_len` is 2 and the displacement is {high byte, low byte}, with the low byte arriving first.
- R6: When bits 7:6 are 00 and bits 2:0 are 110, the form is direct. `disp_len` is 2, `eff_addr` equals {high byte, low byte} with no register added, and `seg_stack` is 0.
- R7: When bits 7:6 are 00 and bits 2:0 are anything other than 110, `disp_len` is 0 and `eff_addr` is the register base alone.
- R8: The register base selected by bits 2:0 is: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP, 111 BX.
- R9: In memory forms, `seg_stack` is 1 exactly when the base uses BP: codes 010 and 011 always, and code 110 unless the form is direct.
- R10: The effective offset is the base plus the displacement taken modulo 2^16.
- R11: After reset, `out_valid` and all decoded outputs are 0. `out_valid` equals the previous cycle's `in_valid`. Inputs presented while `in_valid` is 0 do not change any decoded output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bytes and registers are valid this cycle |
| op_byte | input | 8 | Opcode byte |
| mode_byte | input | 8 | Addressing-mode byte |
| disp_lo | input | 8 | First displacement byte |
| disp_hi | input | 8 | Second displacement byte |
| reg_bx | input | 16 | BX base register value |
| reg_bp | input | 16 | BP base register value |
| reg_si | input | 16 | SI index register value |
| reg_di | input | 16 | DI index register value |
| out_valid | output | 1 | Decoded results valid |
| opc | output | 6 | Opcode field |
| dir_to_reg | output | 1 | Direction: 1 moves data into the register-field operand |
| wide | output | 1 | Width: 1 = word operand |
| reg_sel | output | 3 | Register-field index |
| rm_sel | output | 3 | Register-or-memory field index |
| is_mem | output | 1 | Second operand is in memory |
| disp_len | output | 2 | Displacement bytes that follow (0, 1 or 2) |
| seg_stack | output | 1 | Default segment is stack (1) or data (0) |
| eff_addr | output | 16 | Effective offset |

## Verification
The bench sweeps all 256 mode bytes under every direction/width combination. It uses two register sets, one of which forces carries past bit 15, and four displacement pairs that cover both sign boundaries of the short displacement. A decoder that decoded the direct form as a BP-relative form would return BP plus zero and mark the access for the stack segment. A decoder that zero-extended short displacements would give offsets 0100h too large for the bytes 80h–FFh. Further probes catch three other faults: a short-form decode that leaks the high displacement byte into the sum, an address path that carries into a 17th bit, and a pipeline register that updates while `in_valid` is low.

// File: rtl/amd_pkg.sv
package amd_pkg;

  typedef enum logic [1:0] {
    MOD_NODISP = 2'b00,
    MOD_DISP8  = 2'b01,
    MOD_DISP16 = 2'b10,
    MOD_REGREG = 2'b11
  } amode_e;

  localparam logic [2:0] RM_DIRECT = 3'b110;

  typedef struct packed {
    logic [5:0] opc;
    logic       dir;
    logic       wide;
    amode_e     mode;
    logic [2:0] reg_f;
    logic [2:0] rm_f;
  } hdr_fields_t;

endpackage

// File: rtl/hdr_splitter.sv
module hdr_splitter
  import amd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] op_b,
  input  logic [BYTE_W-1:0] mode_b,
  output hdr_fields_t       fld
);
  always_comb begin
    fld.opc   = op_b[7:2];
    fld.dir   = op_b[1];
    fld.wide  = op_b[0];
    fld.mode  = amode_e'(mode_b[7:6]);
    fld.reg_f = mode_b[5:3];
    fld.rm_f  = mode_b[2:0];
  end
endmodule

// File: rtl/disp_former.sv
module disp_former
  import amd_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  amode_e            mode,
  input  logic [2:0]        rm_f,
  input  logic [BYTE_W-1:0] lo_b,
  input  logic [BYTE_W-1:0] hi_b,
  output logic [OFS_W-1:0]  disp,
  output logic [1:0]        len,
  output logic              direct
);
  localparam int PAD_W = OFS_W - BYTE_W;

  function automatic logic [OFS_W-1:0] widen_signed(input logic [BYTE_W-1:0] b);
    return {{PAD_W{b[BYTE_W-1]}}, b};
  endfunction

  function automatic logic [OFS_W-1:0] join_bytes(input logic [BYTE_W-1:0] l,
                                                  input logic [BYTE_W-1:0] h);
    return {{(OFS_W-2*BYTE_W){1'b0}}, h, l};
  endfunction

  always_comb begin
    direct = (mode == MOD_NODISP) && (rm_f == RM_DIRECT);
    unique case (mode)
      MOD_DISP8: begin
        disp = widen_signed(lo_b);
        len  = 2'd1;
      end
      MOD_DISP16: begin
        disp = join_bytes(lo_b, hi_b);
        len  = 2'd2;
      end
      MOD_NODISP: begin
        disp = direct ? join_bytes(lo_b, hi_b) : '0;
        len  = direct ? 2'd2 : 2'd0;
      end
      default: begin
        disp = '0;
        len  = 2'd0;
      end
    endcase
  end
endmodule

// File: rtl/ea_adder.sv
module ea_adder
  import amd_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  amode_e            mode,
  input  logic [2:0]        rm_f,
  input  logic              direct,
  input  logic [OFS_W-1:0]  bx,
  input  logic [OFS_W-1:0]  bp,
  input  logic [OFS_W-1:0]  si,
  input  logic [OFS_W-1:0]  di,
  input  logic [OFS_W-1:0]  disp,
  output logic [OFS_W-1:0]  ea,
  output logic              stack_seg,
  output logic              mem_op
);
  function automatic logic [OFS_W-1:0] base_of(input logic [2:0] code,
                                               input logic [OFS_W-1:0] b_x,
                                               input logic [OFS_W-1:0] b_p,
                                               input logic [OFS_W-1:0] s_i,
                                               input logic [OFS_W-1:0] d_i);
    logic [OFS_W-1:0] first, second;
    first  = code[1] ? b_p : b_x;
    second = code[0] ? d_i : s_i;
    case (code)
      3'b100:  return s_i;
      3'b101:  return d_i;
      3'b110:  return b_p;
      3'b111:  return b_x;
      default: return first + second;
    endcase
  endfunction

  logic [OFS_W-1:0] base_v;
  logic             uses_bp;

  always_comb begin
    mem_op    = (mode != MOD_REGREG);
    base_v    = direct ? '0 : base_of(rm_f, bx, bp, si, di);
    uses_bp   = (rm_f == 3'b010) || (rm_f == 3'b011) || ((rm_f == 3'b110) && !direct);
    stack_seg = mem_op && uses_bp;
    ea        = mem_op ? (base_v + disp) : '0;
  end

  always_comb begin
    if (direct) begin
      a_direct_no_stack_r6: assert (!stack_seg);
    end
  end
endmodule

// File: rtl/operand_addr_decoder.sv
module operand_addr_decoder
  import amd_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] op_byte,
  input  logic [BYTE_W-1:0] mode_byte,
  input  logic [BYTE_W-1:0] disp_lo,
  input  logic [BYTE_W-1:0] disp_hi,
  input  logic [OFS_W-1:0]  reg_bx,
  input  logic [OFS_W-1:0]  reg_bp,
  input  logic [OFS_W-1:0]  reg_si,
  input  logic [OFS_W-1:0]  reg_di,
  output logic              out_valid,
  output logic [5:0]        opc,
  output logic              dir_to_reg,
  output logic              wide,
  output logic [2:0]        reg_sel,
  output logic [2:0]        rm_sel,
  output logic              is_mem,
  output logic [1:0]        disp_len,
  output logic              seg_stack,
  output logic [OFS_W-1:0]  eff_addr
);
  hdr_fields_t      fld;
  logic [OFS_W-1:0] disp_w;
  logic [1:0]       len_w;
  logic             direct_w;
  logic [OFS_W-1:0] ea_w;
  logic             stack_w;
  logic             mem_w;

  hdr_splitter #(.BYTE_W(BYTE_W)) u_split (
    .op_b  (op_byte),
    .mode_b(mode_byte),
    .fld   (fld)
  );

  disp_former #(.OFS_W(OFS_W), .BYTE_W(BYTE_W)) u_disp (
    .mode  (fld.mode),
    .rm_f  (fld.rm_f),
    .lo_b  (disp_lo),
    .hi_b  (disp_hi),
    .disp  (disp_w),
    .len   (len_w),
    .direct(direct_w)
  );

  ea_adder #(.OFS_W(OFS_W)) u_ea (
    .mode     (fld.mode),
    .rm_f     (fld.rm_f),
    .direct   (direct_w),
    .bx       (reg_bx),
    .bp       (reg_bp),
    .si       (reg_si),
    .di       (reg_di),
    .disp     (disp_w),
    .ea       (ea_w),
    .stack_seg(stack_w),
    .mem_op   (mem_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      opc        <= '0;
      dir_to_reg <= 1'b0;
      wide       <= 1'b0;
      reg_sel    <= '0;
      rm_sel     <= '0;
      is_mem     <= 1'b0;
      disp_len   <= '0;
      seg_stack  <= 1'b0;
      eff_addr   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        opc        <= fld.opc;
        dir_to_reg <= fld.dir;
        wide       <= fld.wide;
        reg_sel    <= fld.reg_f;
        rm_sel     <= fld.rm_f;
        is_mem     <= mem_w;
        disp_len   <= len_w;
        seg_stack  <= stack_w;
        eff_addr   <= ea_w;
      end
    end
  end

  p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(eff_addr) && $stable(reg_sel) && $stable(disp_len)));

  p_regform_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !is_mem) |-> (disp_len == 2'd0 && eff_addr == '0 && !seg_stack));

  p_direct_abs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_byte[7:6] == 2'b00 && mode_byte[2:0] == 3'b110)
      |=> (disp_len == 2'd2 && !seg_stack
           && eff_addr == {{(OFS_W-2*BYTE_W){1'b0}}, $past(disp_hi), $past(disp_lo)}));

  p_short_disp_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && disp_len == 2'd1) |-> is_mem);

  p_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (reg_sel == $past(mode_byte[5:3]) && rm_sel == $past(mode_byte[2:0])));
endmodule

// File: tb/operand_addr_decoder_tb.sv
module operand_addr_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  op_byte = '0, mode_byte = '0, disp_lo = '0, disp_hi = '0;
  logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic        out_valid, dir_to_reg, wide, is_mem, seg_stack;
  logic [5:0]  opc;
  logic [2:0]  reg_sel, rm_sel;
  logic [1:0]  disp_len;
  logic [15:0] eff_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_addr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_byte(op_byte), .mode_byte(mode_byte), .disp_lo(disp_lo), .disp_hi(disp_hi),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .out_valid(out_valid), .opc(opc), .dir_to_reg(dir_to_reg), .wide(wide),
    .reg_sel(reg_sel), .rm_sel(rm_sel), .is_mem(is_mem), .disp_len(disp_len),
    .seg_stack(seg_stack), .eff_addr(eff_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (mode=%02h lo=%02h hi=%02h)",
               tag, act, exp, mode_byte, disp_lo, disp_hi);
    end
  endtask

  function automatic int base_expect(input int rm);
    int bx = int'(reg_bx), bp = int'(reg_bp), si = int'(reg_si), di = int'(reg_di);
    case (rm)
      0: return bx + si;
      1: return bx + di;
      2: return bp + si;
      3: return bp + di;
      4: return si;
      5: return di;
      6: return bp;
      default: return bx;
    endcase
  endfunction

  task automatic check_now;
    int md = int'(mode_byte[7:6]);
    int rm = int'(mode_byte[2:0]);
    int lo = int'(disp_lo), hi = int'(disp_hi);
    int e_len, e_ea, e_stk, e_mem;
    string tag;
    e_mem = (md != 3) ? 1 : 0;
    if (md == 3) begin
      e_len = 0; e_ea = 0; e_stk = 0; tag = "R3";
    end else if (md == 0 && rm == 6) begin
      e_len = 2; e_ea = hi * 256 + lo; e_stk = 0; tag = "R6";
    end else begin
      int d;
      if (md == 1) begin
        d = (lo >= 128) ? (lo - 256) : lo; e_len = 1; tag = "R4 R8 R10";
      end else if (md == 2) begin
        d = hi * 256 + lo; e_len = 2; tag = "R5 R8 R10";
      end else begin
        d = 0; e_len = 0; tag = "R7 R8";
      end
      e_ea = (base_expect(rm) + d) & 16'hFFFF;
      e_stk = (rm == 2 || rm == 3 || rm == 6) ? 1 : 0;
    end
    chk("R11 out_valid", int'(out_valid), 1);
    chk("R1 opc", int'(opc), int'(op_byte[7:2]));
    chk("R1 dir_to_reg", int'(dir_to_reg), int'(op_byte[1]));
    chk("R1 wide", int'(wide), int'(op_byte[0]));
    chk("R2 reg_sel", int'(reg_sel), int'(mode_byte[5:3]));
    chk("R2 rm_sel", int'(rm_sel), rm);
    chk("R3 is_mem", int'(is_mem), e_mem);
    chk({tag, " disp_len"}, int'(disp_len), e_len);
    chk({"R9 ", tag, " seg_stack"}, int'(seg_stack), e_stk);
    chk({tag, " eff_addr"}, int'(eff_addr), e_ea);
  endtask

  task automatic apply_and_check(input logic [7:0] op, input logic [7:0] md,
                                 input logic [7:0] lo, input logic [7:0] hi);
    op_byte = op; mode_byte = md; disp_lo = lo; disp_hi = hi; in_valid = 1'b1;
    @(negedge clk);
    check_now();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] dlo [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    logic [7:0] dhi [4] = '{8'h00, 8'h12, 8'hFF, 8'h80};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset out_valid", int'(out_valid), 0);
    chk("R11 reset eff_addr", int'(eff_addr), 0);
    chk("R11 reset disp_len", int'(disp_len), 0);
    chk("R11 reset is_mem", int'(is_mem), 0);
    rst_n = 1'b1;

    for (int rs = 0; rs < 2; rs++) begin
      if (rs == 0) begin
        reg_bx = 16'h1234; reg_bp = 16'hF000; reg_si = 16'h0011; reg_di = 16'h8000;
      end else begin
        reg_bx = 16'hFFFF; reg_bp = 16'hFFF0; reg_si = 16'h0020; reg_di = 16'hFFFE;
      end
      for (int m = 0; m < 256; m++) begin
        for (int dp = 0; dp < 4; dp++) begin
          apply_and_check({6'b100010, m[1:0] ^ dp[1:0]}, m[7:0], dlo[dp], dhi[dp]);
        end
      end
    end

    // R10 explicit wrap: BX+SI = FFFF + 0002 -> 0001
    reg_bx = 16'hFFFF; reg_si = 16'h0002;
    apply_and_check(8'h8B, 8'h00, 8'h00, 8'h00);
    chk("R10 wrap", int'(eff_addr), 16'h0001);

    // R4 high byte ignored in short form: [DI]+disp8 with hi changed
    reg_di = 16'h0100;
    apply_and_check(8'h8A, 8'h45, 8'h80, 8'h55);
    chk("R4 sext 80h", int'(eff_addr), 16'h0080);

    // R11 inputs ignored while in_valid is low
    in_valid = 1'b0; mode_byte = 8'h86; disp_lo = 8'h34; disp_hi = 8'h12; op_byte = 8'h00;
    @(negedge clk);
    chk("R11 out_valid low", int'(out_valid), 0);
    chk("R11 hold eff_addr", int'(eff_addr), 16'h0080);
    chk("R11 hold disp_len", int'(disp_len), 1);
    chk("R11 hold wide", int'(wide), 0);
    @(negedge clk);
    chk("R11 hold rm_sel", int'(rm_sel), 5);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule